// File: doc/BRIEF.md
# NOR Flash Write-Buffer Program Sequencer

This block loads a run of consecutive 16-bit words into a NOR flash through the device's buffered-programming command, so that one confirm programs the whole run instead of issuing a separate program command for each word. A client pulses `start` with a byte start address and a word count. The block then drives the complete command sequence onto a simple flash write bus (`fl_we`, `fl_addr`, `fl_dq`). The data words come from a valid/ready stream.

On the bus the sequence runs as follows. First come the two unlock writes. Then the load command and the count-minus-one word go to the start address. Next the data words are written to ascending addresses. Last, the confirm command goes to the address of the final word. When that confirm write has finished, the block pulses `done`. Every bus write holds the strobe for a fixed number of cycles and is followed by one idle cycle. The stream is stalled during all bus writes. A request is refused if it arrives while a run is in progress or if it asks for zero words. Polling for completion afterwards is left to other logic.

Top module: `nwb_seq`

## Requirements
- R1: The first two bus writes of a run are data 0x00AA to byte address 0xAAA (word offset 0x555), then data 0x0055 to byte address 0x554 (word offset 0x2AA).
- R2: The third bus write is data 0x0025 to the start address.
- R3: The fourth bus write is the word count minus one, zero-extended to 16 bits, to the start address.
- R4: Data word i (counting from 0) is taken from the stream and written to byte address start + 2·i. All N words are consumed.
- R5: The last bus write is data 0x0029 to byte address start + 2·(N−1). A run is exactly N+5 bus writes.
- R6: A `start` seen while `busy` is high gives a one-cycle `refuse` pulse on the next cycle, gives no `accept`, and leaves the running sequence unchanged.
- R7: A `start` with a word count of 0 while idle gives a `refuse` pulse on the next cycle. It leaves `busy` low and causes no bus write.
- R8: `wd_ready` is high only while the block waits for the next data word, and it is never high while `fl_we` is high.
- R9: Each bus write holds `fl_we` high for exactly WE_CYC consecutive cycles, with `fl_addr` and `fl_dq` stable throughout. At least one low cycle follows before the next write.
- R10: `done` is a one-cycle pulse in the cycle after the idle cycle that ends the confirm write. `busy` is low in that same cycle.
- R11: A `start` with a nonzero count while idle gives a one-cycle `accept` pulse on the next cycle, and `busy` is high from that cycle on. `accept` and `refuse` are never high together.
- R12: While reset is held, `busy`, `accept`, `refuse`, `done`, `wd_ready` and `fl_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a buffered program run |
| start_addr | input | ADDR_W | Byte address of the first word (even) |
| word_cnt | input | CNT_W | Number of words in the run |
| accept | output | 1 | One-cycle pulse: request taken |
| refuse | output | 1 | One-cycle pulse: request refused (busy or zero count) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: confirm write finished |
| wd_valid | input | 1 | Stream word present |
| wd_data | input | DATA_W | Stream word |
| wd_ready | output | 1 | Block takes the stream word this cycle |
| fl_we | output | 1 | Flash write strobe |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_dq | output | DATA_W | Flash write data |

## Verification
`accept` and `refuse` are registered, so each is due one cycle after the `start` that causes it. `done` is due one cycle after the idle cycle that closes the confirm write. The bench drives on the falling edge and samples these flags on the next falling edge. The first bus strobe rises in the same cycle that `accept` is seen, and each write lasts WE_CYC+1 cycles. For this reason the bench does not predict absolute cycle numbers for the bus writes. A falling-edge monitor records each strobe rising edge and measures the width of each strobe, and the ordered write log is compared with the expected address/data list once `done` arrives. `wd_ready` depends only on the state, so the bench decides a handshake from the values it sees at the falling edge before the edge that completes it.

// File: rtl/nwb_pkg.sv
// Shared state encoding and command constants for the write-buffer sequencer.
package nwb_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_UNLK_A, S_UNLK_B, S_LOAD, S_COUNT, S_WAIT, S_DATA, S_CONF
    } seq_st_t;

    localparam int          UNLK_A_BYTE = 'hAAA;   // word offset 0x555
    localparam int          UNLK_B_BYTE = 'h554;   // word offset 0x2AA
    localparam logic [15:0] UNLK_A_DATA = 16'h00AA;
    localparam logic [15:0] UNLK_B_DATA = 16'h0055;
    localparam logic [15:0] LOAD_CMD    = 16'h0025;
    localparam logic [15:0] CONF_CMD    = 16'h0029;
endpackage

// File: rtl/nwb_wr_timer.sv
// Bus write timer: while a write state is active it holds the strobe for
// WE_CYC cycles and then adds one idle cycle, which is flagged by wr_end.
// Assumes active stays high until wr_end has been seen.
module nwb_wr_timer #(
    parameter int WE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic we,
    output logic wr_end
);
    localparam int TW = $clog2(WE_CYC + 1);
    localparam int RW = TW + 1;

    logic [TW-1:0] tcnt_q;
    logic [RW-1:0] run_q;

    // Step through the strobe cycles and the idle cycle of each write.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || wr_end) tcnt_q <= '0;
        else                             tcnt_q <= tcnt_q + 1'b1;
    end

    assign we     = active && (tcnt_q < TW'(WE_CYC));
    assign wr_end = active && (tcnt_q == TW'(WE_CYC));

    // Length of the current strobe run; used only by the assertion.
    always_ff @(posedge clk) begin
        if (!rst_n || !we) run_q <= '0;
        else               run_q <= run_q + 1'b1;
    end

    p_we_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we) |-> (run_q == RW'(WE_CYC)));
endmodule

// File: rtl/nwb_addr_trk.sv
// Address tracker: loads the start address and the count at accept, steps
// the byte address by two for each data word, and reports the last word.
// Assumes word_cnt is nonzero when load is high and that CNT_W <= DATA_W.
module nwb_addr_trk #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  word_cnt,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cnt_m1,
    output logic              last
);
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  rem_q;
    logic [CNT_W-1:0]  cnt_q;

    // Current byte address and the number of words still to write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            addr_q <= start_addr;
            rem_q  <= word_cnt;
            cnt_q  <= word_cnt;
        end else if (step) begin
            addr_q <= addr_q + ADDR_W'(2);
            rem_q  <= rem_q - 1'b1;
        end
    end

    assign cur_addr = addr_q;
    assign cnt_m1   = DATA_W'(cnt_q - 1'b1);
    assign last     = (rem_q == CNT_W'(1));

    p_step_rem_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (rem_q > CNT_W'(1)));
endmodule

// File: rtl/nwb_ctrl.sv
// Sequencer control: moves through unlock, load, count, data and confirm,
// takes stream words in the wait state, drives the bus address/data mux and
// produces the accept/refuse/done pulses. Assumes wr_end comes from the timer.
module nwb_ctrl
    import nwb_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cnt_zero,
    input  logic              wd_valid,
    input  logic [DATA_W-1:0] wd_data,
    input  logic              wr_end,
    input  logic              last,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] cnt_m1,
    output logic              load,
    output logic              step,
    output logic              active,
    output logic              busy,
    output logic              wd_ready,
    output logic              accept,
    output logic              refuse,
    output logic              done,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data
);
    seq_st_t           st_q, st_d;
    logic [DATA_W-1:0] data_q;
    logic              acc_q, ref_q, done_q;

    assign busy     = (st_q != S_IDLE);
    assign wd_ready = (st_q == S_WAIT);
    assign active   = busy && (st_q != S_WAIT);
    assign load     = (st_q == S_IDLE) && start && !cnt_zero;
    assign step     = (st_q == S_DATA) && wr_end && !last;

    // Next-state selection for the command sequence.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:   if (load)     st_d = S_UNLK_A;
            S_UNLK_A: if (wr_end)   st_d = S_UNLK_B;
            S_UNLK_B: if (wr_end)   st_d = S_LOAD;
            S_LOAD:   if (wr_end)   st_d = S_COUNT;
            S_COUNT:  if (wr_end)   st_d = S_WAIT;
            S_WAIT:   if (wd_valid) st_d = S_DATA;
            S_DATA:   if (wr_end)   st_d = last ? S_CONF : S_WAIT;
            S_CONF:   if (wr_end)   st_d = S_IDLE;
            default:                st_d = S_IDLE;
        endcase
    end

    // State register and the registered response pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            acc_q  <= 1'b0;
            ref_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            acc_q  <= load;
            ref_q  <= start && !load;
            done_q <= (st_q == S_CONF) && wr_end;
        end
    end

    // Hold the stream word taken in the wait state for its bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)                      data_q <= '0;
        else if (wd_ready && wd_valid)   data_q <= wd_data;
    end

    // Bus address and data for the write that the current state performs.
    always_comb begin
        bus_addr = '0;
        bus_data = '0;
        unique case (st_q)
            S_UNLK_A: begin bus_addr = ADDR_W'(UNLK_A_BYTE); bus_data = UNLK_A_DATA; end
            S_UNLK_B: begin bus_addr = ADDR_W'(UNLK_B_BYTE); bus_data = UNLK_B_DATA; end
            S_LOAD:   begin bus_addr = cur_addr; bus_data = LOAD_CMD; end
            S_COUNT:  begin bus_addr = cur_addr; bus_data = cnt_m1; end
            S_DATA:   begin bus_addr = cur_addr; bus_data = data_q; end
            S_CONF:   begin bus_addr = cur_addr; bus_data = CONF_CMD; end
            default:  begin bus_addr = '0; bus_data = '0; end
        endcase
    end

    assign accept = acc_q;
    assign refuse = ref_q;
    assign done   = done_q;

    p_conf_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_CONF) |-> last);
endmodule

// File: rtl/nwb_seq.sv
// Write-buffer program sequencer top: connects the control, address tracker
// and bus write timer. Assumes the run fits in one device buffer page and
// that start_addr is even.
module nwb_seq #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 6,
    parameter int DATA_W = 16,
    parameter int WE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  word_cnt,
    output logic              accept,
    output logic              refuse,
    output logic              busy,
    output logic              done,
    input  logic              wd_valid,
    input  logic [DATA_W-1:0] wd_data,
    output logic              wd_ready,
    output logic              fl_we,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_dq
);
    logic              load, step, active, wr_end, last;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cnt_m1;

    nwb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cnt_zero(word_cnt == '0),
        .wd_valid(wd_valid), .wd_data(wd_data), .wr_end(wr_end), .last(last),
        .cur_addr(cur_addr), .cnt_m1(cnt_m1), .load(load), .step(step),
        .active(active), .busy(busy), .wd_ready(wd_ready), .accept(accept),
        .refuse(refuse), .done(done), .bus_addr(fl_addr), .bus_data(fl_dq)
    );

    nwb_addr_trk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .start_addr(start_addr), .word_cnt(word_cnt),
        .cur_addr(cur_addr), .cnt_m1(cnt_m1), .last(last)
    );

    nwb_wr_timer #(.WE_CYC(WE_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .active(active), .we(fl_we), .wr_end(wr_end)
    );

    p_refuse_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> (refuse && !accept));
    p_zero_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && word_cnt == '0) |=> (refuse && !busy));
    p_ready_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wd_ready |-> !fl_we);
    p_bus_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we && $past(fl_we)) |-> ($stable(fl_addr) && $stable(fl_dq)));
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !fl_we));
    p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> busy);
    p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({accept, refuse}));
endmodule

// File: tb/nwb_seq_bench.sv
module nwb_seq_bench;
    localparam int ADDR_W = 24;
    localparam int CNT_W  = 6;
    localparam int DATA_W = 16;
    localparam int WE_CYC = 2;

    // Stimulus table: start address, word count, stream gap, busy-start inject.
    localparam int NV = 4;
    localparam logic [23:0] V_ADDR [NV] = '{24'h001000, 24'h020A40, 24'h00FFF8, 24'h123450};
    localparam int          V_CNT  [NV] = '{1, 4, 8, 3};
    localparam int          V_GAP  [NV] = '{0, 0, 2, 1};
    localparam bit          V_INJ  [NV] = '{1'b0, 1'b1, 1'b0, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [CNT_W-1:0]  word_cnt = '0;
    logic wd_valid = 1'b0;
    logic [DATA_W-1:0] wd_data = '0;
    logic accept, refuse, busy, done, wd_ready, fl_we;
    logic [ADDR_W-1:0] fl_addr;
    logic [DATA_W-1:0] fl_dq;

    int checks = 0;
    int errors = 0;
    int cyc_all = 0;

    logic [ADDR_W-1:0] log_a [512];
    logic [DATA_W-1:0] log_d [512];
    int  n_log = 0;
    int  run_len = 0;
    logic prev_we = 1'b0;

    always #2.5 clk = ~clk;

    nwb_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .WE_CYC(WE_CYC)) u_nwb_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .word_cnt(word_cnt), .accept(accept), .refuse(refuse), .busy(busy),
        .done(done), .wd_valid(wd_valid), .wd_data(wd_data), .wd_ready(wd_ready),
        .fl_we(fl_we), .fl_addr(fl_addr), .fl_dq(fl_dq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] dfun(input logic [15:0] seed, input int i);
        return (seed ^ 16'h5A00) + 16'(i) * 16'h0101;
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc_all++;
        if (cyc_all > 100000) begin
            errors++;
            $display("FAIL watchdog act=%0d exp=<100000", cyc_all);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Bus monitor: logs each write, checks strobe width, stability and ready.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fl_we && !prev_we) begin
                log_a[n_log % 512] = fl_addr;
                log_d[n_log % 512] = fl_dq;
                n_log++;
                run_len = 1;
                chk(!wd_ready, "R8 ready low during write", 32'(wd_ready), 0);
            end else if (fl_we) begin
                run_len++;
                chk(fl_addr == log_a[(n_log-1) % 512] && fl_dq == log_d[(n_log-1) % 512],
                    "R9 bus stable", 32'(fl_addr), 32'(log_a[(n_log-1) % 512]));
            end else if (prev_we) begin
                chk(run_len == WE_CYC, "R9 strobe width", 32'(run_len), 32'(WE_CYC));
            end
            prev_we = fl_we;
        end
    end

    task automatic run_seq(input logic [23:0] a, input int n, input int gap, input bit inj);
        int  base, idx;
        bit  fire, seen;
        logic [23:0] ea;
        logic [15:0] ed;
        string tag;
        @(negedge clk);
        base = n_log;
        start = 1'b1; start_addr = a; word_cnt = CNT_W'(n);
        @(negedge clk);
        chk(accept === 1'b1 && busy === 1'b1, "R11 accept and busy", {accept, busy}, 2'b11);
        start = 1'b0;
        idx = 0; fire = 1'b0; seen = 1'b0;
        for (int cyc = 0; cyc < 3000 && !seen; cyc++) begin
            if (cyc > 0) @(negedge clk);
            if (fire) begin idx++; wd_valid = 1'b0; end
            if (done) begin
                seen = 1'b1;
                chk(!busy, "R10 busy low at done", 32'(busy), 0);
            end
            if (inj && cyc == 4) begin
                start = 1'b1; start_addr = 24'h003000; word_cnt = CNT_W'(5);
            end
            if (inj && cyc == 5) begin
                chk(refuse === 1'b1 && accept === 1'b0, "R6 refuse while busy", {refuse, accept}, 2'b10);
                start = 1'b0;
            end
            if (!seen && !wd_valid && idx < n && (cyc % (gap + 1)) == 0) begin
                wd_valid = 1'b1;
                wd_data  = dfun(a[15:0], idx);
            end
            fire = wd_valid && wd_ready;
        end
        chk(seen, "R10 done seen", 32'(seen), 1);
        chk(idx == n, "R4 words consumed", 32'(idx), 32'(n));
        chk(n_log - base == n + 5, "R5 write count", 32'(n_log - base), 32'(n + 5));
        for (int k = 0; k < n + 5 && k < n_log - base; k++) begin
            if (k == 0)          begin ea = 24'hAAA; ed = 16'h00AA; tag = "R1 unlock A"; end
            else if (k == 1)     begin ea = 24'h554; ed = 16'h0055; tag = "R1 unlock B"; end
            else if (k == 2)     begin ea = a; ed = 16'h0025; tag = "R2 load cmd"; end
            else if (k == 3)     begin ea = a; ed = 16'(n - 1); tag = "R3 count word"; end
            else if (k < n + 4)  begin ea = a + 24'(2 * (k - 4)); ed = dfun(a[15:0], k - 4); tag = "R4 data word"; end
            else                 begin ea = a + 24'(2 * (n - 1)); ed = 16'h0029; tag = "R5 confirm"; end
            chk(log_a[(base + k) % 512] == ea, {tag, " addr"}, 32'(log_a[(base + k) % 512]), 32'(ea));
            chk(log_d[(base + k) % 512] == ed, {tag, " data"}, 32'(log_d[(base + k) % 512]), 32'(ed));
        end
        @(negedge clk);
        chk(!done, "R10 done one cycle", 32'(done), 0);
    endtask

    initial begin
        int base;
        // R12: reset state.
        repeat (3) @(negedge clk);
        chk({busy, accept, refuse, done, wd_ready, fl_we} == 6'b0, "R12 reset outputs",
            32'({busy, accept, refuse, done, wd_ready, fl_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) run_seq(V_ADDR[v], V_CNT[v], V_GAP[v], V_INJ[v]);

        // R7: zero count refused with no bus activity.
        @(negedge clk);
        base = n_log;
        start = 1'b1; start_addr = 24'h004000; word_cnt = '0;
        @(negedge clk);
        chk(refuse === 1'b1 && accept === 1'b0, "R7 zero count refused", {refuse, accept}, 2'b10);
        chk(!busy, "R7 stays idle", 32'(busy), 0);
        start = 1'b0;
        repeat (10) @(negedge clk);
        chk(n_log == base && !fl_we && !busy, "R7 no bus write", 32'(n_log - base), 0);

        // R11: a fresh run after the refusal still works.
        run_seq(24'h000200, 2, 0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule